// File: doc/BRIEF.md
# Banked External Interrupt Router

This block gathers peripheral interrupt lines in banks of 32 and drives a small set of core trigger outputs, typically one per hardware thread. Every line has a status bit, a sense-select bit (edge or level), an enable bit and a route register. Together they decide whether the line is pending and which trigger it asserts. Software reaches all of this state through a single-cycle 32-bit register port.

A line's number splits into a bank index (number divided by 32) and a bit position (number modulo 32). Edge lines latch a rising edge of their synchronized input into the status bit. Level lines mirror the synchronized input. A software write of 1 to a status bit toggles it, which lets software clear an edge event or raise the line again. A route value of zero detaches a line from every trigger. The enable registers can be left out at build time, and lines then pass unconditionally.

Register map, byte addresses on a 16-bit port: status of bank b at 0x0000 + 8*b; sense-select at 0x0100 + 8*b; enable at 0x0200 + 8*b; route of line i in bank b at 0x4000 + 0x1000*b + 4*i. Bit i of the status, sense and enable words belongs to line 32*b + i.

Top module: `ext_irq_router`

## Requirements
- R1: Line n is held at bank n/32, bit n mod 32. Its status, sense and enable bits sit in the words at 0x0000, 0x0100 and 0x0200 plus 8*bank. Its route register sits at 0x4000 + 0x1000*bank + 4*bit.
- R2: After reset, all status, sense, enable and route registers read 0 and trig_o is 0.
- R3: On an edge line (sense bit 0), a rising edge of the input sets the status bit. The status changes on the third clock edge after the input changes, because of the two synchronizer stages. The bit stays set after the input falls.
- R4: On a level line (sense bit 1), the status bit equals the synchronized input. A write of 1 to its status bit while the input is low raises the status for exactly one cycle. While the input is high, the bit stays 1.
- R5: Writing a word to a status register toggles every edge-line bit written as 1 and leaves the bits written as 0 unchanged. This clears a pending edge or retriggers a cleared one.
- R6: If a hardware rising edge and a software toggle hit the same edge-line status bit in the same cycle, the bit ends up set.
- R7: An enable bit of 1 lets a pending line reach its trigger and 0 blocks it, while the status bit is still recorded. With HAS_MASK=0, enable words read 0xFFFFFFFF, writes to them are ignored, and every line passes.
- R8: A route value v of 1..NUM_TRIG drives trig_o[v-1]. A route value of 0, or any value above NUM_TRIG, drives no trigger. Route registers hold the low clog2(NUM_TRIG+1) bits of the written word.
- R9: trig_o[t] is a register that equals the OR, over all lines routed to t, of status AND enable, one cycle after the status changes.
- R10: A read request returns the addressed register on rsp_rdata_o with rsp_valid_o high in the next cycle. Writes produce no response. An address outside the map, or a bank at or beyond NUM_BANKS, reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NUM_BANKS*32 | Peripheral interrupt lines, asynchronous |
| req_valid_i | input | 1 | Register access request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 16 | Byte address |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata_o | output | 32 | Read data |
| trig_o | output | NUM_TRIG | Core trigger outputs |

## Verification
The assertions check every cycle that a rising edge on an edge line leaves its status set, that level lines track their synchronized input, that toggle writes flip exactly the written edge bits, and that an edge wins over a same-cycle toggle. They also check that no trigger rises while nothing is pending and enabled, and that read responses follow reads one to one. Only the bench scenarios can show the address map, the exact synchronizer and output latency, the one-cycle pulse from a level retrigger, route decoding including zero and out-of-range values, the OR of several lines onto one trigger, and the build without enable registers.

// File: rtl/ext_irq_pkg.sv
`timescale 1ns/1ps
package ext_irq_pkg;
  parameter int unsigned LINES_PER_BANK = 32;
  parameter int unsigned LINE_IDX_W     = 5;
  parameter int unsigned ADDR_W         = 16;
  parameter int unsigned DATA_W         = 32;

  typedef enum logic [1:0] {RK_STAT = 2'd0, RK_LVL = 2'd1, RK_MSK = 2'd2, RK_VEC = 2'd3} reg_kind_e;

  typedef struct packed {
    logic                  hit;
    reg_kind_e             kind;
    logic [1:0]            bank;
    logic [LINE_IDX_W-1:0] line;
  } reg_sel_t;

  function automatic reg_sel_t decode_addr(input logic [ADDR_W-1:0] a);
    reg_sel_t s;
    s = '0;
    if (a[15:10] == 6'd0 && a[9:8] != 2'b11 && a[7:5] == 3'd0 && a[2:0] == 3'd0) begin
      s.hit  = 1'b1;
      s.kind = reg_kind_e'(a[9:8]);
      s.bank = a[4:3];
    end else if (a[15:14] == 2'b01 && a[11:7] == 5'd0 && a[1:0] == 2'd0) begin
      s.hit  = 1'b1;
      s.kind = RK_VEC;
      s.bank = a[13:12];
      s.line = a[6:2];
    end
    return s;
  endfunction
endpackage

// File: rtl/eir_sync.sv
`timescale 1ns/1ps
module eir_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else             stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/eir_bank.sv
`timescale 1ns/1ps
module eir_bank
  import ext_irq_pkg::*;
#(
  parameter int unsigned VEC_W    = 3,
  parameter bit          HAS_MASK = 1'b1
) (
  input  logic                                     clk_i,
  input  logic                                     rst_ni,
  input  logic [LINES_PER_BANK-1:0]                irq_s_i,
  input  logic                                     wr_stat_i,
  input  logic                                     wr_lvl_i,
  input  logic                                     wr_msk_i,
  input  logic                                     wr_vec_i,
  input  logic [LINE_IDX_W-1:0]                    wr_line_i,
  input  logic [DATA_W-1:0]                        wdata_i,
  output logic [LINES_PER_BANK-1:0]                stat_o,
  output logic [LINES_PER_BANK-1:0]                lvl_o,
  output logic [LINES_PER_BANK-1:0]                msk_o,
  output logic [LINES_PER_BANK-1:0][VEC_W-1:0]     vec_o
);
  logic [LINES_PER_BANK-1:0] stat_q, lvl_q, s_d_q;
  logic [LINES_PER_BANK-1:0] rise, tog, stat_n;

  assign rise = irq_s_i & ~s_d_q;
  assign tog  = wr_stat_i ? wdata_i : '0;
  // level: mirror input, a toggle write pulses it; edge: toggle, then edge wins
  assign stat_n = (lvl_q & (irq_s_i | tog)) | (~lvl_q & ((stat_q ^ tog) | rise));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      lvl_q  <= '0;
      s_d_q  <= '0;
    end else begin
      stat_q <= stat_n;
      s_d_q  <= irq_s_i;
      if (wr_lvl_i) lvl_q <= wdata_i;
    end
  end

  if (HAS_MASK) begin : g_msk
    logic [LINES_PER_BANK-1:0] msk_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       msk_q <= '0;
      else if (wr_msk_i) msk_q <= wdata_i;
    end
    assign msk_o = msk_q;
  end else begin : g_nomsk
    logic unused_msk;
    assign unused_msk = wr_msk_i;
    assign msk_o      = '1;
  end

  for (genvar i = 0; i < LINES_PER_BANK; i++) begin : g_vec
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vec_o[i] <= '0;
      else if (wr_vec_i && wr_line_i == LINE_IDX_W'(i)) vec_o[i] <= wdata_i[VEC_W-1:0];
    end
  end

  assign stat_o = stat_q;
  assign lvl_o  = lvl_q;

  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rise & ~lvl_q)) |=> ((stat_q & $past(rise & ~lvl_q)) == $past(rise & ~lvl_q))); // R3
  AST_LEVEL_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lvl_q & ~tog)) |=> ((stat_q & $past(lvl_q & ~tog)) == $past(irq_s_i & lvl_q & ~tog))); // R4
  AST_TOGGLE_FLIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tog) |=> (((stat_q ^ $past(stat_q)) & $past(tog & ~lvl_q & ~rise)) == $past(tog & ~lvl_q & ~rise))); // R5
  AST_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(tog & rise & ~lvl_q)) |=> ((stat_q & $past(tog & rise & ~lvl_q)) == $past(tog & rise & ~lvl_q))); // R6
endmodule

// File: rtl/eir_route.sv
`timescale 1ns/1ps
module eir_route #(
  parameter int unsigned NUM_LINES = 64,
  parameter int unsigned NUM_TRIG  = 4,
  parameter int unsigned VEC_W     = 3
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [NUM_LINES-1:0]             act_i,
  input  logic [NUM_LINES-1:0][VEC_W-1:0]  vec_i,
  output logic [NUM_TRIG-1:0]              trig_o
);
  logic [NUM_TRIG-1:0] hit;

  always_comb begin
    hit = '0;
    for (int t = 0; t < NUM_TRIG; t++) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        if (act_i[l] && vec_i[l] == VEC_W'(t + 1)) hit[t] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trig_o <= '0;
    else         trig_o <= hit;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|act_i) |=> (trig_o == '0)); // R9
endmodule

// File: rtl/ext_irq_router.sv
`timescale 1ns/1ps
module ext_irq_router
  import ext_irq_pkg::*;
#(
  parameter int unsigned NUM_BANKS   = 2,
  parameter int unsigned NUM_TRIG    = 4,
  parameter bit          HAS_MASK    = 1'b1,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [NUM_BANKS*LINES_PER_BANK-1:0]  irq_i,
  input  logic                                 req_valid_i,
  input  logic                                 req_write_i,
  input  logic [ADDR_W-1:0]                    req_addr_i,
  input  logic [DATA_W-1:0]                    req_wdata_i,
  output logic                                 rsp_valid_o,
  output logic [DATA_W-1:0]                    rsp_rdata_o,
  output logic [NUM_TRIG-1:0]                  trig_o
);
  localparam int unsigned NUM_LINES = NUM_BANKS * LINES_PER_BANK;
  localparam int unsigned VEC_W     = $clog2(NUM_TRIG + 1);

  reg_sel_t sel;
  logic     bank_ok, wr_en;
  logic [NUM_LINES-1:0] irq_s, act;
  logic [NUM_LINES-1:0][VEC_W-1:0] vec_flat;
  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0] stat_all, lvl_all, msk_all;
  logic [NUM_BANKS-1:0][LINES_PER_BANK-1:0][VEC_W-1:0] vec_all;
  logic [DATA_W-1:0] rd_data;

  assign sel     = decode_addr(req_addr_i);
  assign bank_ok = sel.hit && (int'(sel.bank) < NUM_BANKS);
  assign wr_en   = req_valid_i && req_write_i && bank_ok;

  eir_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (irq_s)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic here;
    assign here = wr_en && (sel.bank == 2'(b));

    eir_bank #(.VEC_W(VEC_W), .HAS_MASK(HAS_MASK)) u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .irq_s_i  (irq_s[b*LINES_PER_BANK +: LINES_PER_BANK]),
      .wr_stat_i(here && sel.kind == RK_STAT),
      .wr_lvl_i (here && sel.kind == RK_LVL),
      .wr_msk_i (here && sel.kind == RK_MSK),
      .wr_vec_i (here && sel.kind == RK_VEC),
      .wr_line_i(sel.line),
      .wdata_i  (req_wdata_i),
      .stat_o   (stat_all[b]),
      .lvl_o    (lvl_all[b]),
      .msk_o    (msk_all[b]),
      .vec_o    (vec_all[b])
    );

    assign act[b*LINES_PER_BANK +: LINES_PER_BANK] = stat_all[b] & msk_all[b];
    for (genvar i = 0; i < LINES_PER_BANK; i++) begin : g_flat
      assign vec_flat[b*LINES_PER_BANK + i] = vec_all[b][i];
    end
  end

  eir_route #(.NUM_LINES(NUM_LINES), .NUM_TRIG(NUM_TRIG), .VEC_W(VEC_W)) u_route (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .vec_i (vec_flat),
    .trig_o(trig_o)
  );

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_ok && sel.bank == 2'(b)) begin
        unique case (sel.kind)
          RK_STAT: rd_data = stat_all[b];
          RK_LVL:  rd_data = lvl_all[b];
          RK_MSK:  rd_data = msk_all[b];
          RK_VEC:  rd_data = DATA_W'(vec_all[b][sel.line]);
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i && !req_write_i;
      if (req_valid_i && !req_write_i) rsp_rdata_o <= rd_data;
    end
  end

  AST_RSP_FOLLOWS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o); // R10
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o); // R10
endmodule

// File: tb/ext_irq_router_bench.sv
`timescale 1ns/1ps
module ext_irq_router_bench;
  localparam int NB = 2;
  localparam int NT = 4;
  localparam int NL = NB * 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [NL-1:0] irq   = '0;
  logic          rv = 1'b0, rw = 1'b0;
  logic [15:0]   raddr = '0;
  logic [31:0]   wdata = '0;
  logic          rsp_v, nm_rsp_v;
  logic [31:0]   rsp_d, nm_rsp_d;
  logic [NT-1:0] trig, nm_trig;

  ext_irq_router #(.NUM_BANKS(NB), .NUM_TRIG(NT), .HAS_MASK(1'b1)) u_ext_irq_router (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_valid_i(rv), .req_write_i(rw),
    .req_addr_i(raddr), .req_wdata_i(wdata), .rsp_valid_o(rsp_v), .rsp_rdata_o(rsp_d),
    .trig_o(trig));

  ext_irq_router #(.NUM_BANKS(1), .NUM_TRIG(NT), .HAS_MASK(1'b0)) u_ext_irq_router_nm (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq[31:0]), .req_valid_i(rv), .req_write_i(rw),
    .req_addr_i(raddr), .req_wdata_i(wdata), .rsp_valid_o(nm_rsp_v), .rsp_rdata_o(nm_rsp_d),
    .trig_o(nm_trig));

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] a_st(input int b);     return 16'(b * 8); endfunction
  function automatic logic [15:0] a_lv(input int b);     return 16'(16'h0100 + b * 8); endfunction
  function automatic logic [15:0] a_mk(input int b);     return 16'(16'h0200 + b * 8); endfunction
  function automatic logic [15:0] a_vc(input int b, input int l);
    return 16'(16'h4000 + b * 16'h1000 + l * 4);
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    rv = 1'b1; rw = 1'b1; raddr = a; wdata = d;
    @(negedge clk);
    rv = 1'b0; rw = 1'b0;
  endtask

  // driver: pushes the expected read value, monitor pops it on response
  task automatic bus_rd(input logic [15:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    rv = 1'b1; rw = 1'b0; raddr = a;
    @(negedge clk);
    rv = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && rsp_v) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R10: unexpected response got %h expected none", rsp_d);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.tag, rsp_d, it.exp);
      end
    end
  end

  initial begin
    #(500_000.0);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R2 reset state
    chk("R2 trig", 32'(trig), 0);
    chk("R2 nm trig", 32'(nm_trig), 0);
    bus_rd(a_st(0), 0, "R2 status");
    bus_rd(a_lv(1), 0, "R2 sense");
    bus_rd(a_mk(0), 0, "R2 enable");
    bus_rd(a_vc(1, 31), 0, "R2 route");

    bus_wr(a_vc(0, 3), 1);
    bus_wr(a_mk(0), 32'h28);
    bus_wr(a_vc(0, 5), 2);

    // R3 edge capture with sync latency, R9 output one cycle later
    irq[3] = 1'b1;
    tick(3);
    chk("R9 trig not yet", 32'(trig), 0);
    tick(1);
    chk("R3 edge trig", 32'(trig), 1);
    bus_rd(a_st(0), 32'h8, "R3 status set");
    irq[3] = 1'b0;
    tick(4);
    bus_rd(a_st(0), 32'h8, "R3 sticky after fall");

    // R5 toggle clear and retrigger
    bus_wr(a_st(0), 32'h8);
    chk("R9 trig lags status", 32'(trig), 1);
    tick(1);
    chk("R5 cleared", 32'(trig), 0);
    bus_rd(a_st(0), 0, "R5 status cleared");
    bus_wr(a_st(0), 32'h8);
    tick(1);
    chk("R5 retrigger", 32'(trig), 1);

    // R7 enable gating; build without enables passes everything
    bus_wr(a_mk(0), 32'h20);
    tick(1);
    chk("R7 masked", 32'(trig), 0);
    chk("R7 no-enable build", 32'(nm_trig), 1);
    bus_rd(a_st(0), 32'h8, "R7 status kept");
    bus_rd(a_mk(0), 32'h20, "R7 enable read");
    chk("R7 no-enable read", nm_rsp_d, 32'hFFFF_FFFF);
    bus_wr(a_mk(0), 32'h28);
    tick(1);
    chk("R7 unmasked", 32'(trig), 1);
    bus_wr(a_st(0), 32'h8);
    tick(1);
    chk("R5 clear again", 32'(trig), 0);

    // R6 edge and toggle in one cycle: bit was 1, a toggle alone would clear
    bus_wr(a_st(0), 32'h20);
    irq[5] = 1'b1;
    tick(2);
    bus_wr(a_st(0), 32'h20);
    bus_rd(a_st(0), 32'h20, "R6 status");
    chk("R6 trig", 32'(trig), 32'h2);
    irq[5] = 1'b0;

    // R8 route decoding
    bus_wr(a_vc(0, 5), 0);
    tick(1);
    chk("R8 zero route", 32'(trig), 0);
    bus_wr(a_vc(0, 5), 7);
    tick(1);
    chk("R8 out of range", 32'(trig), 0);
    bus_wr(a_vc(0, 5), 32'hFFFF_FFF4);
    tick(1);
    chk("R8 route 4", 32'(trig), 32'h8);
    bus_rd(a_vc(0, 5), 4, "R8 route readback");

    // R9 OR of several lines on one trigger
    bus_wr(a_vc(0, 3), 4);
    bus_wr(a_st(0), 32'h8);
    bus_wr(a_st(0), 32'h20);
    tick(1);
    chk("R9 OR keeps trig", 32'(trig), 32'h8);
    bus_wr(a_st(0), 32'h8);
    tick(1);
    chk("R9 all clear", 32'(trig), 0);

    // R4 level line 40 = bank 1 bit 8 (R1)
    bus_wr(a_lv(1), 32'h100);
    bus_wr(a_mk(1), 32'h100);
    bus_wr(a_vc(1, 8), 3);
    irq[40] = 1'b1;
    tick(3);
    bus_rd(a_st(1), 32'h100, "R1 R4 level status");
    chk("R4 level trig", 32'(trig), 32'h4);
    irq[40] = 1'b0;
    tick(3);
    bus_rd(a_st(1), 0, "R4 level follows input");
    chk("R4 level trig off", 32'(trig), 0);
    bus_wr(a_st(1), 32'h100);
    chk("R4 pulse pending", 32'(trig), 0);
    tick(1);
    chk("R4 pulse", 32'(trig), 32'h4);
    tick(1);
    chk("R4 pulse ends", 32'(trig), 0);
    irq[40] = 1'b1;
    tick(4);
    bus_wr(a_st(1), 32'h100);
    bus_rd(a_st(1), 32'h100, "R4 write keeps high level");
    irq[40] = 1'b0;
    bus_rd(a_lv(1), 32'h100, "R1 sense bank 1");

    // R10 unmapped space
    bus_wr(16'h0004, 32'hFFFF_FFFF);
    bus_rd(a_st(0), 0, "R10 unmapped write ignored");
    bus_rd(16'h0010, 0, "R10 absent bank");
    bus_rd(16'h0300, 0, "R10 hole");
    tick(2);
    chk("R10 queue drained", 32'(sb_q.size()), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule